// File: doc/BRIEF.md
# SPI Burst Register Access Bridge

This block is an SPI slave (mode 0: data sampled on the rising SCLK edge, changed on the falling edge, MSB first, 32-bit words) that turns framed SPI transactions into accesses on an internal 32-bit register bus. A frame opens with one 32-bit header word. The header holds an opcode, a 16-bit byte address and a count of data words. For a write, the data words follow in the same chip-select frame, and each completed word becomes one bus write. For a read, the slave shifts the requested words out on MISO in the same frame. The address steps by four bytes per word.

SCLK, chip select and MOSI are oversampled by the system clock through synchronizers. Every bus access carries a region select, decoded from its address: the control-register region, the controller-register window or the message RAM window. Addresses past the end of the map produce no bus access. During a read the bridge fetches one word ahead. The next word is then already in the bridge when its first bit has to appear on MISO. The bus handshake is simple: a request is held until the bus returns a single-cycle acknowledge. SCLK half periods must span enough system clocks to cover the synchronizer and one bus round trip.

Top module: `spi_burst_bridge`

## Requirements
- R1: Header fields: bits 31:24 are the opcode (0x61 = write, 0x41 = read), bits 23:8 are the start address and bits 7:0 are the word count. Bits are sampled on rising SCLK and MISO changes on falling SCLK, MSB first.
- R2: In a write frame, each completed data word issues exactly one bus write of that word. The k-th word (k from 0) goes to the start address plus 4·k.
- R3: In a read frame, the k-th word after the header is the bus read data of the start address plus 4·k, shifted out MSB first.
- R4: Reads are fetched one word ahead. Exactly one bus read is issued per requested word in range, and none beyond the count.
- R5: A count field of 0 behaves exactly as a count of 1.
- R6: Region select is 0 for 0x0000–0x0FFF, 1 for 0x1000–0x7FFF and 2 for 0x8000–0x8FFF. An address above 0x8FFF issues no bus access: reads return zero and writes are dropped.
- R7: An opcode other than 0x41 or 0x61 causes the rest of the frame to be ignored, with no bus access and MISO held at 0. It sets `spi_err`, which stays at 1 until reset.
- R8: Releasing chip select mid-word discards the partial word without any bus access, and the next frame starts again with a header.
- R9: Words clocked beyond the count are ignored. They cause no bus access, and MISO stays 0 during them.
- R10: A bus request holds its address, direction, select and write data stable until the acknowledge, and each acknowledged request matches one expected access.
- R11: After reset, `spi_miso`, `bus_req` and `spi_err` are 0.
- R12: MISO is 0 while chip select is released and during the header word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock (idle low) |
| spi_csn | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from master |
| spi_miso | output | 1 | Serial data to master |
| bus_req | output | 1 | Register bus request, held until acknowledged |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 16 | Byte address of the access |
| bus_sel | output | 2 | Region select: 0 control, 1 controller, 2 message RAM |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with acknowledge |
| bus_ack | input | 1 | Single-cycle acknowledge |
| spi_err | output | 1 | Sticky invalid-opcode flag |

## Verification
A stale or miscounted bit counter shows up as a wrongly framed header within one word: the bus access carries a shifted address or the wrong direction, or no access appears at all. Errors in the address step or the burst count appear at the first acknowledged bus transfer that differs from the expected access list, or as an access left over or missing at the end of a frame. A broken prefetch shows on MISO at the first bit of the affected word, because every read bit is compared on the master side before the rising edge that samples it. A lost sticky error flag is visible on `spi_err` by the end of the frame that follows.

// File: rtl/sbb_pkg.sv
package sbb_pkg;
    localparam int WORD_W = 32;
    localparam int ADDR_W = 16;
    localparam int LEN_W  = 8;
    localparam int OP_W   = WORD_W - ADDR_W - LEN_W;

    localparam logic [OP_W-1:0] OP_WRITE = 8'h61;
    localparam logic [OP_W-1:0] OP_READ  = 8'h41;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_CORE = 2'd1,
        SEL_RAM  = 2'd2,
        SEL_NONE = 2'd3
    } sel_e;

    typedef enum logic [1:0] {
        PH_HDR = 2'd0,
        PH_WR  = 2'd1,
        PH_RD  = 2'd2,
        PH_IGN = 2'd3
    } phase_e;
endpackage

// File: rtl/sbb_sclk_sync.sv
module sbb_sclk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic csn_i,
    input  logic mosi_i,
    output logic rise_o,
    output logic fall_o,
    output logic cs_act_o,
    output logic mosi_o
);
    localparam int SW = STAGES + 1;

    logic [SW-1:0]     sclk_d, sclk_q;
    logic [STAGES-1:0] csn_d, csn_q;
    logic [STAGES-1:0] mosi_d, mosi_q;

    always_comb begin
        sclk_d = {sclk_q[SW-2:0], sclk_i};
        csn_d  = {csn_q[STAGES-2:0], csn_i};
        mosi_d = {mosi_q[STAGES-2:0], mosi_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= '0;
            csn_q  <= '1;
            mosi_q <= '0;
        end else begin
            sclk_q <= sclk_d;
            csn_q  <= csn_d;
            mosi_q <= mosi_d;
        end
    end

    assign rise_o   =  sclk_q[STAGES-1] & ~sclk_q[STAGES];
    assign fall_o   = ~sclk_q[STAGES-1] &  sclk_q[STAGES];
    assign cs_act_o = ~csn_q[STAGES-1];
    assign mosi_o   =  mosi_q[STAGES-1];
endmodule

// File: rtl/sbb_region_dec.sv
module sbb_region_dec
    import sbb_pkg::*;
#(
    parameter logic [ADDR_W-1:0] CORE_BASE = 16'h1000,
    parameter logic [ADDR_W-1:0] RAM_BASE  = 16'h8000,
    parameter logic [ADDR_W-1:0] ADDR_LAST = 16'h8FFF
) (
    input  logic [ADDR_W-1:0] addr_i,
    output sel_e              sel_o
);
    always_comb begin
        if (addr_i > ADDR_LAST)       sel_o = SEL_NONE;
        else if (addr_i >= RAM_BASE)  sel_o = SEL_RAM;
        else if (addr_i >= CORE_BASE) sel_o = SEL_CORE;
        else                          sel_o = SEL_CTRL;
    end
endmodule

// File: rtl/spi_burst_bridge.sv
module spi_burst_bridge
    import sbb_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] CORE_BASE   = 16'h1000,
    parameter logic [ADDR_W-1:0] RAM_BASE    = 16'h8000,
    parameter logic [ADDR_W-1:0] ADDR_LAST   = 16'h8FFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_csn,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_sel,
    output logic [WORD_W-1:0] bus_wdata,
    input  logic [WORD_W-1:0] bus_rdata,
    input  logic              bus_ack,
    output logic              spi_err
);
    localparam int CNT_W = $clog2(WORD_W);
    localparam int REM_W = LEN_W + 1;
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_W / 8);
    localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(WORD_W - 1);

    typedef struct packed {
        phase_e             phase;
        logic [CNT_W-1:0]   bit_cnt;
        logic [WORD_W-1:0]  sh_in;
        logic [WORD_W-1:0]  sh_out;
        logic [WORD_W-1:0]  pref;
        logic [ADDR_W-1:0]  addr;
        logic [REM_W-1:0]   remain;
        logic               req;
        logic               we;
        logic [ADDR_W-1:0]  baddr;
        sel_e               bsel;
        logic [WORD_W-1:0]  wdata;
        logic               err;
    } st_t;

    st_t d, q;

    logic rise, fall, cs_act, mosi_s;
    logic [WORD_W-1:0] sh_next;
    logic [ADDR_W-1:0] dec_addr;
    sel_e              dec_sel;

    logic [OP_W-1:0]   hdr_op;
    logic [ADDR_W-1:0] hdr_addr;
    logic [LEN_W-1:0]  hdr_len;

    sbb_sclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_i   (spi_sclk),
        .csn_i    (spi_csn),
        .mosi_i   (spi_mosi),
        .rise_o   (rise),
        .fall_o   (fall),
        .cs_act_o (cs_act),
        .mosi_o   (mosi_s)
    );

    // Address that the next bus access would use, by phase
    always_comb begin
        sh_next  = {q.sh_in[WORD_W-2:0], mosi_s};
        hdr_op   = sh_next[WORD_W-1 -: OP_W];
        hdr_addr = sh_next[LEN_W +: ADDR_W];
        hdr_len  = sh_next[LEN_W-1:0];
        case (q.phase)
            PH_HDR:  dec_addr = hdr_addr;
            PH_RD:   dec_addr = q.addr + STEP;
            default: dec_addr = q.addr;
        endcase
    end

    sbb_region_dec #(
        .CORE_BASE (CORE_BASE),
        .RAM_BASE  (RAM_BASE),
        .ADDR_LAST (ADDR_LAST)
    ) u_dec (
        .addr_i (dec_addr),
        .sel_o  (dec_sel)
    );

    always_comb begin
        d = q;
        if (q.req && bus_ack) begin
            d.req = 1'b0;
            if (!q.we) d.pref = bus_rdata;
        end
        if (!cs_act) begin
            d.phase   = PH_HDR;
            d.bit_cnt = '0;
            d.sh_in   = '0;
            d.sh_out  = '0;
        end else begin
            if (rise) begin
                d.sh_in   = sh_next;
                d.bit_cnt = q.bit_cnt + CNT_W'(1);
                if (q.bit_cnt == LAST_BIT) begin
                    case (q.phase)
                        PH_HDR: begin
                            d.addr   = hdr_addr;
                            d.remain = (hdr_len == '0) ? REM_W'(1) : REM_W'(hdr_len);
                            if (hdr_op == OP_WRITE) begin
                                d.phase = PH_WR;
                            end else if (hdr_op == OP_READ) begin
                                d.phase = PH_RD;
                                d.pref  = '0;
                                if (dec_sel != SEL_NONE) begin
                                    d.req   = 1'b1;
                                    d.we    = 1'b0;
                                    d.baddr = hdr_addr;
                                    d.bsel  = dec_sel;
                                end
                            end else begin
                                d.phase = PH_IGN;
                                d.err   = 1'b1;
                            end
                        end
                        PH_WR: begin
                            if (q.remain != '0) begin
                                d.remain = q.remain - REM_W'(1);
                                d.addr   = q.addr + STEP;
                                if (dec_sel != SEL_NONE) begin
                                    d.req   = 1'b1;
                                    d.we    = 1'b1;
                                    d.baddr = q.addr;
                                    d.bsel  = dec_sel;
                                    d.wdata = sh_next;
                                end
                            end
                        end
                        default: ;
                    endcase
                end
            end
            if (fall) begin
                if (q.phase == PH_RD && q.bit_cnt == '0 && q.remain != '0) begin
                    d.sh_out = q.pref;
                    d.remain = q.remain - REM_W'(1);
                    if (q.remain > REM_W'(1)) begin
                        d.addr = q.addr + STEP;
                        d.pref = '0;
                        if (dec_sel != SEL_NONE) begin
                            d.req   = 1'b1;
                            d.we    = 1'b0;
                            d.baddr = q.addr + STEP;
                            d.bsel  = dec_sel;
                        end
                    end
                end else begin
                    d.sh_out = {q.sh_out[WORD_W-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.phase <= PH_HDR;
            q.bsel  <= SEL_NONE;
        end else begin
            q <= d;
        end
    end

    assign spi_miso  = q.sh_out[WORD_W-1];
    assign bus_req   = q.req;
    assign bus_we    = q.we;
    assign bus_addr  = q.baddr;
    assign bus_sel   = q.bsel;
    assign bus_wdata = q.wdata;
    assign spi_err   = q.err;

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)
                                   && $stable(bus_sel) && $stable(bus_wdata)));
    // R6
    req_in_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (bus_addr <= ADDR_LAST && bus_sel != 2'd3));
    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_err |=> spi_err);
    // R12
    miso_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !spi_miso);
    // R7
    ign_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_IGN && !bus_req) |=> !bus_req);
endmodule

// File: tb/sim_spi_burst_bridge.sv
module sim_spi_burst_bridge;
    localparam int CLK_PER = 10;
    localparam int HP      = 12;
    localparam int WDOG    = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_sclk = 1'b0, spi_csn = 1'b1, spi_mosi = 1'b0;
    logic        spi_miso, bus_req, bus_we, bus_ack, spi_err;
    logic [15:0] bus_addr;
    logic [1:0]  bus_sel;
    logic [31:0] bus_wdata, bus_rdata;

    int compared = 0, mismatched = 0;
    logic [31:0] mem [logic [15:0]];
    logic        eq_we [$];
    logic [15:0] eq_addr [$];
    logic [1:0]  eq_sel [$];
    logic [31:0] eq_data [$];
    string       eq_tag [$];
    logic        exp_err = 1'b0;
    bit          done = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    spi_burst_bridge u0 (
        .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_csn(spi_csn),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .bus_req(bus_req),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .spi_err(spi_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] sel_of(input logic [15:0] a);
        if (a > 16'h8FFF) return 2'd3;
        if (a >= 16'h8000) return 2'd2;
        if (a >= 16'h1000) return 2'd1;
        return 2'd0;
    endfunction

    function automatic logic [31:0] rd(input logic [15:0] a);
        if (sel_of(a) == 2'd3) return 32'h0;
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    task automatic expect_acc(input logic we, input logic [15:0] a,
                              input logic [31:0] dat, input string tag);
        if (sel_of(a) != 2'd3) begin
            eq_we.push_back(we); eq_addr.push_back(a); eq_sel.push_back(sel_of(a));
            eq_data.push_back(dat); eq_tag.push_back(tag);
        end
    endtask

    // bus responder: two-cycle latency, per-access comparison
    initial begin
        int wait_c;
        wait_c = 0;
        bus_ack = 1'b0;
        bus_rdata = '0;
        forever begin
            @(negedge clk);
            if (bus_ack) begin
                bus_ack = 1'b0;
                wait_c = 0;
            end else if (rst_n && bus_req) begin
                wait_c++;
                if (wait_c == 2) begin
                    if (eq_we.size() == 0) begin
                        chk("R10 unexpected access addr", {16'h0, bus_addr}, 32'hFFFF_FFFF);
                    end else begin
                        string t;
                        logic [15:0] ea;
                        logic [31:0] ed;
                        logic ew;
                        logic [1:0] es;
                        t = eq_tag.pop_front(); ea = eq_addr.pop_front();
                        ew = eq_we.pop_front(); es = eq_sel.pop_front(); ed = eq_data.pop_front();
                        chk({t, " R1 dir"}, {31'h0, bus_we}, {31'h0, ew});
                        chk({t, " addr"}, {16'h0, bus_addr}, {16'h0, ea});
                        chk({t, " R6 sel"}, {30'h0, bus_sel}, {30'h0, es});
                        if (ew) chk({t, " wdata"}, bus_wdata, ed);
                    end
                    if (bus_we) mem[bus_addr] = bus_wdata;
                    else bus_rdata = rd(bus_addr);
                    bus_ack = 1'b1;
                end
            end
        end
    end

    task automatic xfer_bits(input logic [31:0] w, input int n, output logic [31:0] got);
        got = '0;
        for (int i = 31; i >= 32 - n; i--) begin
            spi_mosi = w[i];
            repeat (HP) @(negedge clk);
            got[i] = spi_miso;
            spi_sclk = 1'b1;
            repeat (HP) @(negedge clk);
            spi_sclk = 1'b0;
        end
    endtask

    task automatic frame_open();
        spi_csn = 1'b0;
        repeat (HP) @(negedge clk);
    endtask

    task automatic frame_close();
        repeat (HP) @(negedge clk);
        spi_csn = 1'b1;
        repeat (3 * HP) @(negedge clk);
        chk("R12 miso idle", {31'h0, spi_miso}, 32'h0);
    endtask

    task automatic do_write(input logic [15:0] a, input logic [7:0] lenf, input int nsent,
                            input logic [31:0] seed, input string tag);
        int eff;
        logic [31:0] got;
        eff = (lenf == 0) ? 1 : int'(lenf);
        for (int k = 0; k < eff && k < nsent; k++)
            expect_acc(1'b1, a + 16'(4 * k), seed + 32'(k) * 32'h1111_1111, tag);
        frame_open();
        xfer_bits({8'h61, a, lenf}, 32, got);
        for (int k = 0; k < nsent; k++)
            xfer_bits(seed + 32'(k) * 32'h1111_1111, 32, got);
        frame_close();
    endtask

    task automatic do_read(input logic [15:0] a, input logic [7:0] lenf, input int nclk,
                           input string tag);
        int eff;
        logic [31:0] got;
        eff = (lenf == 0) ? 1 : int'(lenf);
        for (int k = 0; k < eff; k++) expect_acc(1'b0, a + 16'(4 * k), 32'h0, tag);
        frame_open();
        xfer_bits({8'h41, a, lenf}, 32, got);
        chk({tag, " R12 header miso"}, got, 32'h0);
        for (int k = 0; k < nclk; k++) begin
            xfer_bits(32'h0, 32, got);
            if (k < eff) chk({tag, " R3 R4 data"}, got, rd(a + 16'(4 * k)));
            else         chk({tag, " R9 beyond count"}, got, 32'h0);
        end
        frame_close();
    endtask

    initial begin
        int cyc;
        cyc = 0;
        while (!done) begin
            @(negedge clk);
            cyc++;
            if (cyc > WDOG) begin
                chk("watchdog", 32'h1, 32'h0);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] got;
        repeat (5) @(negedge clk);
        chk("R11 miso", {31'h0, spi_miso}, 32'h0);
        chk("R11 req", {31'h0, bus_req}, 32'h0);
        chk("R11 err", {31'h0, spi_err}, 32'h0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        do_write(16'h1000, 8'd3, 3, 32'hA5C3_0F01, "R2 burst");
        do_read (16'h1000, 8'd3, 3, "R3 burst");
        do_write(16'h0020, 8'd0, 2, 32'h1234_5678, "R5 R9 write");
        do_read (16'h0020, 8'd0, 2, "R5 read");
        do_read (16'h0024, 8'd1, 1, "R9 unwritten");
        do_write(16'h0FF8, 8'd3, 3, 32'h0BAD_F00D, "R6 cross");
        do_read (16'h0FF8, 8'd3, 3, "R6 cross");
        do_write(16'h8FFC, 8'd2, 2, 32'hCAFE_0001, "R6 ram end");
        do_read (16'h8FFC, 8'd2, 2, "R6 ram end");
        chk("R7 err clear before", {31'h0, spi_err}, 32'h0);

        frame_open();
        xfer_bits({8'h55, 16'h1000, 8'd2}, 32, got);
        xfer_bits(32'hFFFF_FFFF, 32, got);
        chk("R7 miso after bad opcode", got, 32'h0);
        xfer_bits(32'hFFFF_FFFF, 32, got);
        frame_close();
        exp_err = 1'b1;
        chk("R7 err set", {31'h0, spi_err}, {31'h0, exp_err});

        frame_open();
        xfer_bits({8'h61, 16'h0040, 8'd1}, 32, got);
        xfer_bits(32'hDEAD_BEEF, 20, got);
        frame_close();
        frame_open();
        xfer_bits({8'h41, 16'h0040, 8'd1}, 12, got);
        frame_close();
        do_read(16'h0040, 8'd1, 1, "R8 abort");
        do_read(16'h1004, 8'd2, 2, "R3 after abort");
        chk("R7 err sticky", {31'h0, spi_err}, {31'h0, exp_err});

        repeat (20) @(negedge clk);
        chk("R4 no leftover access", 32'(eq_we.size()), 32'h0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule